// File: doc/BRIEF.md
# One-Hot Tagged L1 Cache Tag Store

This block is the tag store of a small write-through L1 data cache that keeps no address bits in its tags. Each line instead records a one-hot vector that names the TLB entry translating it. A lookup presents a set index together with the TLB's one-hot match vector for the access. A line hits when it is valid and its stored vector shares a set bit with that match vector. No wide physical tag comparator is needed.

When the TLB throws an entry out, it signals the entry's index. Every line in every set and way whose vector points at that entry is then marked invalid in a single clock. The cache is write-through, so dropping lines this way never discards modified data. Fills store the match vector of the missing access as the new tag. Within a two-way set, the way to replace is taken from one least-recently-used bit per set.

Top module: `ptag_store`

## Requirements
- R1: After reset every line is invalid, so every lookup misses, and every set's LRU bit is 0, so the first fill to any set goes to way 0 (`fill_way` = 0).
- R2: `lk_hit` is high in the same cycle, combinationally, when the line in way w of set `lk_set` is valid and its tag ANDed with `lk_match` is nonzero. `lk_way` then gives that way, or way 0 when both ways hit.
- R3: A zero `lk_match`, meaning a TLB miss, always gives `lk_hit` = 0.
- R4: An accepted fill writes `fill_vec` as the tag of way `fill_way` in set `fill_set` and sets the line valid. A lookup with that set and vector hits from the next cycle on.
- R5: A fill whose `fill_vec` does not have exactly one bit set is ignored. It writes no line and leaves the LRU bit unchanged.
- R6: When `evict_en` is high, every line in every set and way whose tag has bit `evict_idx` set becomes invalid at the next clock edge. Lines whose tags point at other entries keep their state.
- R7: A fill is dropped when `evict_en` is high in the same cycle and `fill_vec` has bit `evict_idx` set. A dropped fill writes nothing and does not update the LRU bit. A fill for a different entry in that cycle proceeds normally.
- R8: The LRU bit of a set names the way that the next fill will use (`fill_way`). A lookup hit with `lk_en` high in way w sets it to the other way. An accepted fill into way w does the same.
- R9: A lookup hit and an accepted fill can update the same set in the same cycle. In that case the update from the fill decides the LRU bit.
- R10: A lookup in the cycle of an eviction still sees the state from before the eviction. The invalidated lines miss from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_en | input | 1 | Marks a real access, so that a hit updates the LRU bit |
| lk_set | input | 6 | Set index of the lookup |
| lk_match | input | 32 | One-hot TLB match vector of the access |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Way that hit |
| fill_en | input | 1 | Fill request |
| fill_set | input | 6 | Set index to fill |
| fill_vec | input | 32 | One-hot TLB entry vector written as the tag |
| fill_way | output | 1 | Way that a fill to `fill_set` would use (the LRU bit) |
| evict_en | input | 1 | TLB entry eviction strobe |
| evict_idx | input | 5 | Index of the evicted TLB entry |

## Verification
The assertions check the following on every cycle:
- a zero match vector never hits;
- only one-hot vectors reach the tag arrays;
- after an eviction with no fill, no valid line still points at the evicted entry;
- an accepted fill hits on the next cycle;
- the LRU bit flips on each hit and fill, with the fill taking precedence.

Only the bench's scenarios can show the rest:
- eviction leaves lines for other entries intact across sets;
- a dropped or malformed fill leaves no trace in either the tags or the LRU choice;
- a lookup in the eviction cycle still hits.

// File: rtl/ptag_pkg.sv
package ptag_pkg;
    localparam int PT_TLB_N = 32;
    localparam int PT_SETS  = 64;
    localparam int PT_WAYS  = 2;

    function automatic logic one_hot32(input logic [PT_TLB_N-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/ptag_bank.sv
module ptag_bank #(
    parameter int TLB_N = 32,
    parameter int SETS  = 64,
    localparam int SET_W = $clog2(SETS),
    localparam int IDX_W = $clog2(TLB_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_valid,
    output logic [TLB_N-1:0] rd_vec,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TLB_N-1:0] wr_vec,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    typedef struct packed {
        logic [SETS-1:0]            valid;
        logic [SETS-1:0][TLB_N-1:0] tag;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inv_en) begin
            for (int s = 0; s < SETS; s++) begin
                if (st_q.tag[s][inv_idx]) st_d.valid[s] = 1'b0;
            end
        end
        if (wr_en) begin
            st_d.valid[wr_set] = 1'b1;
            st_d.tag[wr_set]   = wr_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.tag   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid[rd_set];
    assign rd_vec   = st_q.tag[rd_set];

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_vec) == 1)); // R5
    AST_FLASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !wr_en) |=> !(rd_valid && rd_vec[$past(inv_idx)])); // R6
endmodule

// File: rtl/ptag_lru.sv
module ptag_lru #(
    parameter int SETS = 64,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_way,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  logic             hit_way,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_way
);
    typedef struct packed {
        logic [SETS-1:0] next_way;
    } lru_t;

    lru_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_en) st_d.next_way[hit_set] = ~hit_way;
        if (upd_en) st_d.next_way[upd_set] = ~upd_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_way = st_q.next_way[rd_set];

    AST_LRU_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (st_q.next_way[$past(upd_set)] == ~$past(upd_way))); // R9
    AST_LRU_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !(upd_en && upd_set == hit_set))
        |=> (st_q.next_way[$past(hit_set)] == ~$past(hit_way))); // R8
endmodule

// File: rtl/ptag_store.sv
module ptag_store
    import ptag_pkg::*;
#(
    parameter int TLB_N = PT_TLB_N,
    parameter int SETS  = PT_SETS,
    localparam int WAYS  = PT_WAYS,
    localparam int SET_W = $clog2(SETS),
    localparam int IDX_W = $clog2(TLB_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TLB_N-1:0] lk_match,
    output logic             lk_hit,
    output logic             lk_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TLB_N-1:0] fill_vec,
    output logic             fill_way,
    input  logic             evict_en,
    input  logic [IDX_W-1:0] evict_idx
);
    logic [WAYS-1:0]            way_valid;
    logic [WAYS-1:0][TLB_N-1:0] way_vec;
    logic [WAYS-1:0]            way_hit;
    logic                       fill_ok;
    logic                       fill_shape_ok;
    logic                       fill_clash;

    always_comb begin
        fill_shape_ok = (fill_vec != '0) && ((fill_vec & (fill_vec - 1'b1)) == '0);
        fill_clash    = evict_en && fill_vec[evict_idx];
        fill_ok       = fill_en && fill_shape_ok && !fill_clash;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ptag_bank #(.TLB_N(TLB_N), .SETS(SETS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_set   (lk_set),
            .rd_valid (way_valid[w]),
            .rd_vec   (way_vec[w]),
            .wr_en    (fill_ok && (fill_way == w[0])),
            .wr_set   (fill_set),
            .wr_vec   (fill_vec),
            .inv_en   (evict_en),
            .inv_idx  (evict_idx)
        );
        assign way_hit[w] = way_valid[w] && ((way_vec[w] & lk_match) != '0);
    end

    assign lk_hit = |way_hit;
    assign lk_way = !way_hit[0];

    ptag_lru #(.SETS(SETS)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (fill_set),
        .rd_way  (fill_way),
        .hit_en  (lk_en && lk_hit),
        .hit_set (lk_set),
        .hit_way (lk_way),
        .upd_en  (fill_ok),
        .upd_set (fill_set),
        .upd_way (fill_way)
    );

    AST_ZERO_MATCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_match == '0) |-> !lk_hit); // R3
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |=> (!((lk_set == $past(fill_set)) && (lk_match == $past(fill_vec))) || lk_hit)); // R4
    AST_CLASH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_clash) |-> !fill_ok); // R7
endmodule

// File: tb/ptag_store_test.sv
module ptag_store_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_EVICT = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  set;
        logic [31:0] vec;
        logic        hit;
        logic        way;
    } step_t;

    // For FILL, 'way' is the expected fill_way. For EVICT, vec[4:0] is the index.
    localparam step_t STEPS [18] = '{
        '{OP_FILL,  6'd3,  32'h0000_0020, 1'b0, 1'b0},  // R1 R4 fresh set -> way0
        '{OP_LOOK,  6'd3,  32'h0000_0020, 1'b1, 1'b0},  // R2
        '{OP_LOOK,  6'd3,  32'h0000_0000, 1'b0, 1'b0},  // R3
        '{OP_LOOK,  6'd3,  32'h0000_0040, 1'b0, 1'b0},  // R2 no shared bit
        '{OP_FILL,  6'd3,  32'h0000_0040, 1'b0, 1'b1},  // R8 hit way0 -> way1
        '{OP_LOOK,  6'd3,  32'h0000_0240, 1'b1, 1'b1},  // R2
        '{OP_FILL,  6'd3,  32'h0000_0080, 1'b0, 1'b0},  // R8 hit way1 -> way0
        '{OP_LOOK,  6'd3,  32'h0000_0020, 1'b0, 1'b0},  // R4 replaced
        '{OP_LOOK,  6'd3,  32'h0000_0080, 1'b1, 1'b0},  // R4
        '{OP_FILL,  6'd10, 32'h0000_0080, 1'b0, 1'b0},  // R1
        '{OP_FILL,  6'd20, 32'h0000_0080, 1'b0, 1'b0},  // R1
        '{OP_EVICT, 6'd0,  32'h0000_0007, 1'b0, 1'b0},  // R6
        '{OP_LOOK,  6'd3,  32'h0000_0080, 1'b0, 1'b0},  // R6
        '{OP_LOOK,  6'd10, 32'h0000_0080, 1'b0, 1'b0},  // R6
        '{OP_LOOK,  6'd3,  32'h0000_0040, 1'b1, 1'b1},  // R6 other entry kept
        '{OP_FILL,  6'd3,  32'h0000_0003, 1'b0, 1'b0},  // R5 ignored
        '{OP_LOOK,  6'd3,  32'h0000_0003, 1'b0, 1'b0},  // R5 nothing written
        '{OP_FILL,  6'd3,  32'h0000_0004, 1'b0, 1'b0}   // R5 LRU unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_en = 1'b0;
    logic [5:0]  lk_set = '0;
    logic [31:0] lk_match = '0;
    logic        lk_hit, lk_way;
    logic        fill_en = 1'b0;
    logic [5:0]  fill_set = '0;
    logic [31:0] fill_vec = '0;
    logic        fill_way;
    logic        evict_en = 1'b0;
    logic [4:0]  evict_idx = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptag_store uut (
        .clk(clk), .rst_n(rst_n),
        .lk_en(lk_en), .lk_set(lk_set), .lk_match(lk_match),
        .lk_hit(lk_hit), .lk_way(lk_way),
        .fill_en(fill_en), .fill_set(fill_set), .fill_vec(fill_vec), .fill_way(fill_way),
        .evict_en(evict_en), .evict_idx(evict_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_en = 1'b0; fill_en = 1'b0; evict_en = 1'b0;
        lk_match = '0; fill_vec = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        lk_set = 6'd3; lk_match = 32'hFFFF_FFFF; fill_set = 6'd3;
        #1;
        check("R1 hit after reset", {31'd0, lk_hit}, 32'd0);
        check("R1 fill_way after reset", {31'd0, fill_way}, 32'd0);
        idle();

        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            idle();
            case (STEPS[i].op)
                OP_FILL:  begin fill_en = 1'b1; fill_set = STEPS[i].set; fill_vec = STEPS[i].vec; end
                OP_LOOK:  begin lk_en = 1'b1; lk_set = STEPS[i].set; lk_match = STEPS[i].vec; end
                default:  begin evict_en = 1'b1; evict_idx = STEPS[i].vec[4:0]; end
            endcase
            #1;
            if (STEPS[i].op == OP_FILL)
                check($sformatf("R8 table step %0d fill_way", i), {31'd0, fill_way}, {31'd0, STEPS[i].way});
            if (STEPS[i].op == OP_LOOK) begin
                check($sformatf("R2 table step %0d hit", i), {31'd0, lk_hit}, {31'd0, STEPS[i].hit});
                if (STEPS[i].hit)
                    check($sformatf("R2 table step %0d way", i), {31'd0, lk_way}, {31'd0, STEPS[i].way});
            end
        end

        // R7: fill clashing with an eviction of the same entry is dropped
        @(negedge clk); idle();
        fill_en = 1'b1; fill_set = 6'd40; fill_vec = 32'h0000_1000;
        evict_en = 1'b1; evict_idx = 5'd12;
        @(negedge clk); idle();
        lk_set = 6'd40; lk_match = 32'h0000_1000; fill_set = 6'd40;
        #1;
        check("R7 dropped fill wrote nothing", {31'd0, lk_hit}, 32'd0);
        check("R7 dropped fill kept LRU", {31'd0, fill_way}, 32'd0);
        // R7: fill of a different entry in an eviction cycle proceeds
        @(negedge clk); idle();
        fill_en = 1'b1; fill_set = 6'd41; fill_vec = 32'h0000_2000;
        evict_en = 1'b1; evict_idx = 5'd12;
        @(negedge clk); idle();
        lk_set = 6'd41; lk_match = 32'h0000_2000;
        #1;
        check("R7 unrelated fill accepted", {31'd0, lk_hit}, 32'd1);

        // R9: hit and fill on the same set in one cycle, fill decides LRU
        @(negedge clk); idle();
        fill_en = 1'b1; fill_set = 6'd50; fill_vec = 32'h0000_0002;
        @(negedge clk); idle();
        lk_en = 1'b1; lk_set = 6'd50; lk_match = 32'h0000_0002;
        fill_en = 1'b1; fill_set = 6'd50; fill_vec = 32'h0000_0004;
        #1;
        check("R9 hit before combined update", {31'd0, lk_hit}, 32'd1);
        check("R9 fill goes to way1", {31'd0, fill_way}, 32'd1);
        @(negedge clk); idle();
        fill_set = 6'd50;
        #1;
        check("R9 fill update wins LRU", {31'd0, fill_way}, 32'd0);

        // R10: lookup in the eviction cycle still hits, then misses
        @(negedge clk); idle();
        lk_set = 6'd50; lk_match = 32'h0000_0002;
        evict_en = 1'b1; evict_idx = 5'd1;
        #1;
        check("R10 hit in eviction cycle", {31'd0, lk_hit}, 32'd1);
        @(negedge clk); idle();
        lk_set = 6'd50; lk_match = 32'h0000_0002;
        #1;
        check("R10 miss after eviction", {31'd0, lk_hit}, 32'd0);
        lk_match = 32'h0000_0004;
        #1;
        check("R6 other way of set kept", {31'd0, lk_hit}, 32'd1);
        check("R2 hitting way reported", {31'd0, lk_way}, 32'd1);

        @(negedge clk); idle();
        summary();
    end
endmodule